// File: doc/BRIEF.md
# Packet Acknowledge Policy Controller

This block sets the acknowledge policy of a packet radio link. On the transmit side it turns each payload-load command into the one-bit no-acknowledge flag that goes into the packet's control field. A load command is either normal or marked as "no acknowledge". The marked kind only takes effect when dynamic acknowledgement is enabled. A polarity bit can swap the meaning of the flag.

The flag and the intent behind it are fixed when the payload is loaded. They are held in a small ordered queue, one entry per loaded payload, until that payload is reported as transmitted. When the packet leaves, the block requests light sleep if that packet needs no acknowledgement, or if auto-acknowledgement is disabled. Otherwise the transmitter keeps waiting for an acknowledgement.

On the receive side, the block looks at each valid received packet that passed its CRC, together with the decoded flag. It issues a one-cycle request to send an acknowledgement when auto-acknowledgement is on and the flag, read through the same polarity bit, asks for one.

Top module: `ackp_ctrl`

## Requirements
- R1: During and right after a synchronous reset, `ack_req`, `sleep_req`, `tx_flag_vld` and `tx_flag` are all 0, and the payload queue is empty.
- R2: A normal load (`load_noack`=0) queues an entry whose flag equals `cfg_flag_inv` (flag 0 when not inverted, 1 when inverted), and whose packet waits for an acknowledgement.
- R3: A no-ack load (`load_noack`=1) while `cfg_dyn_ack`=1 queues an entry whose flag is the inverse of `cfg_flag_inv`, and whose packet needs no acknowledgement.
- R4: A no-ack load while `cfg_dyn_ack`=0 is handled exactly like a normal load.
- R5: The flag and the no-ack intent are fixed when the payload is loaded. Later changes of `cfg_flag_inv` or `cfg_dyn_ack` do not alter queued entries. `tx_flag` always shows the oldest queued entry, in load order.
- R6: The queue holds up to DEPTH entries (default 3). A load arriving while the queue is full is dropped.
- R7: A `tx_sent` pulse removes the oldest entry. In the next cycle, `sleep_req` pulses for one cycle if that entry needed no acknowledgement or `cfg_auto_ack`=0. A `tx_sent` pulse with an empty queue has no effect.
- R8: In the cycle after `rx_valid`=1 with `rx_crc_ok`=1 and `cfg_auto_ack`=1, `ack_req` pulses for one cycle exactly when `rx_flag` equals `cfg_flag_inv`.
- R9: While `cfg_auto_ack`=0, `ack_req` never rises, and every transmitted packet leads to `sleep_req`.
- R10: A received packet with `rx_crc_ok`=0 never causes `ack_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_auto_ack | input | 1 | Auto-acknowledgement enable |
| cfg_dyn_ack | input | 1 | Lets no-ack load commands take effect |
| cfg_flag_inv | input | 1 | Swaps the polarity of the no-ack flag |
| load_valid | input | 1 | One-cycle payload-load command |
| load_noack | input | 1 | Marks the load command as no-ack |
| tx_sent | input | 1 | Oldest queued payload has been transmitted |
| rx_valid | input | 1 | Received packet strobe |
| rx_crc_ok | input | 1 | Received packet passed its CRC |
| rx_flag | input | 1 | Decoded no-ack flag of the received packet |
| tx_flag | output | 1 | Flag value for the oldest queued payload |
| tx_flag_vld | output | 1 | Queue holds at least one payload |
| ack_req | output | 1 | One-cycle request to send an acknowledgement |
| sleep_req | output | 1 | One-cycle request for the transmitter to sleep |

## Verification
A wrong queue pointer or count shows up within one cycle at the port. `tx_flag_vld` stays high on an empty queue or low on a filled one, or `tx_flag` shows an entry out of load order. A corrupted stored intent bit shows up as a missing or extra `sleep_req` in the cycle after the matching `tx_sent`. Faults in the receive decision show up in the cycle right after the strobe. The random phase keeps changing the polarity, the enables and the queue fill level, so stale entries are compared against entries loaded under other settings.

// File: rtl/ackp_pkg.sv
package ackp_pkg;
  typedef struct packed {
    logic noack;  // packet needs no acknowledgement
    logic flag;   // on-air flag value
  } ackp_entry_t;
endpackage

// File: rtl/ackp_tx_encode.sv
module ackp_tx_encode
  import ackp_pkg::*;
(
  input  logic        cfg_dyn_ack,
  input  logic        cfg_flag_inv,
  input  logic        load_noack,
  output ackp_entry_t entry
);
  logic want_noack;
  always_comb begin
    want_noack  = load_noack & cfg_dyn_ack;
    entry.noack = want_noack;
    entry.flag  = want_noack ^ cfg_flag_inv;
  end
endmodule

// File: rtl/ackp_flag_queue.sv
module ackp_flag_queue
  import ackp_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        push,
  input  ackp_entry_t push_data,
  input  logic        pop,
  output ackp_entry_t head,
  output logic        not_empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  ackp_entry_t   mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign do_push = push && (count != FULLC);
  assign do_pop  = pop && (count != '0);

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign not_empty = (count != '0);
  always_comb begin
    head = mem[rd_ptr];
    if (!not_empty) head = '0;
  end
endmodule

// File: rtl/ackp_rx_decide.sv
module ackp_rx_decide (
  input  logic clk,
  input  logic rst,
  input  logic cfg_auto_ack,
  input  logic cfg_flag_inv,
  input  logic rx_valid,
  input  logic rx_crc_ok,
  input  logic rx_flag,
  output logic ack_req
);
  always_ff @(posedge clk) begin
    if (rst) ack_req <= 1'b0;
    else     ack_req <= rx_valid & rx_crc_ok & cfg_auto_ack & (rx_flag == cfg_flag_inv);
  end
endmodule

// File: rtl/ackp_ctrl.sv
module ackp_ctrl
  import ackp_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic cfg_auto_ack,
  input  logic cfg_dyn_ack,
  input  logic cfg_flag_inv,
  input  logic load_valid,
  input  logic load_noack,
  input  logic tx_sent,
  input  logic rx_valid,
  input  logic rx_crc_ok,
  input  logic rx_flag,
  output logic tx_flag,
  output logic tx_flag_vld,
  output logic ack_req,
  output logic sleep_req
);
  ackp_entry_t new_entry, head;
  logic        not_empty;

  ackp_tx_encode u_enc (
    .cfg_dyn_ack (cfg_dyn_ack),
    .cfg_flag_inv(cfg_flag_inv),
    .load_noack  (load_noack),
    .entry       (new_entry)
  );

  ackp_flag_queue #(.DEPTH(DEPTH)) u_q (
    .clk      (clk),
    .rst      (rst),
    .push     (load_valid),
    .push_data(new_entry),
    .pop      (tx_sent),
    .head     (head),
    .not_empty(not_empty)
  );

  ackp_rx_decide u_rx (
    .clk         (clk),
    .rst         (rst),
    .cfg_auto_ack(cfg_auto_ack),
    .cfg_flag_inv(cfg_flag_inv),
    .rx_valid    (rx_valid),
    .rx_crc_ok   (rx_crc_ok),
    .rx_flag     (rx_flag),
    .ack_req     (ack_req)
  );

  always_ff @(posedge clk) begin
    if (rst) sleep_req <= 1'b0;
    else     sleep_req <= tx_sent & not_empty & (~cfg_auto_ack | head.noack);
  end

  assign tx_flag     = head.flag;
  assign tx_flag_vld = not_empty;
endmodule

// File: rtl/ackp_ctrl_checker.sv
module ackp_ctrl_checker (
  input logic clk,
  input logic rst,
  input logic cfg_auto_ack,
  input logic cfg_flag_inv,
  input logic load_valid,
  input logic load_noack,
  input logic tx_sent,
  input logic rx_valid,
  input logic rx_crc_ok,
  input logic rx_flag,
  input logic tx_flag,
  input logic tx_flag_vld,
  input logic ack_req,
  input logic sleep_req
);
  assert_ack_gate_R10: assert property (@(posedge clk) disable iff (rst)
    ack_req |-> $past(rx_valid && rx_crc_ok && cfg_auto_ack));
  assert_ack_polarity_R8: assert property (@(posedge clk) disable iff (rst)
    ack_req |-> $past(rx_flag == cfg_flag_inv));
  assert_sleep_cause_R7: assert property (@(posedge clk) disable iff (rst)
    sleep_req |-> $past(tx_sent && tx_flag_vld));
  assert_sleep_noauto_R9: assert property (@(posedge clk) disable iff (rst)
    (tx_sent && tx_flag_vld && !cfg_auto_ack) |=> sleep_req);
  assert_load_fills_R6: assert property (@(posedge clk) disable iff (rst)
    (load_valid && !tx_flag_vld) |=> tx_flag_vld);
  assert_normal_flag_R2: assert property (@(posedge clk) disable iff (rst)
    (load_valid && !load_noack && !tx_flag_vld) |=> (tx_flag == $past(cfg_flag_inv)));
endmodule

bind ackp_ctrl ackp_ctrl_checker u_chk (.*);

// File: tb/ackp_ctrl_bench.sv
module ackp_ctrl_bench;
  localparam int DEPTH = 3;
  logic clk = 1'b0, rst = 1'b1;
  logic cfg_auto_ack = 0, cfg_dyn_ack = 0, cfg_flag_inv = 0;
  logic load_valid = 0, load_noack = 0, tx_sent = 0;
  logic rx_valid = 0, rx_crc_ok = 0, rx_flag = 0;
  logic tx_flag, tx_flag_vld, ack_req, sleep_req;

  int checks = 0, errors = 0;
  logic [1:0] mq[$];   // {noack, flag}
  logic e_ack = 0, e_sleep = 0;

  always #4 clk = ~clk;

  ackp_ctrl #(.DEPTH(DEPTH)) u_ackp_ctrl (.*);

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  function automatic logic exp_flag();
    return (mq.size() > 0) ? mq[0][0] : 1'b0;
  endfunction

  task automatic check_all(string req);
    chk(req, "ack_req", ack_req, e_ack);
    chk(req, "sleep_req", sleep_req, e_sleep);
    chk(req, "tx_flag_vld", tx_flag_vld, mq.size() > 0);
    chk(req, "tx_flag", tx_flag, exp_flag());
  endtask

  // called at a negedge: drive, model the next edge, check at next negedge
  task automatic cyc(string req, logic lv, logic ln, logic ts, logic rv, logic rc, logic rf);
    logic nq;
    logic full;
    load_valid = lv; load_noack = ln; tx_sent = ts;
    rx_valid = rv; rx_crc_ok = rc; rx_flag = rf;
    full    = mq.size() >= DEPTH;
    e_sleep = ts && mq.size() > 0 && (!cfg_auto_ack || mq[0][1]);
    e_ack   = rv && rc && cfg_auto_ack && (rf == cfg_flag_inv);
    nq      = ln && cfg_dyn_ack;
    if (ts && mq.size() > 0) void'(mq.pop_front());
    if (lv && !full) mq.push_back({nq, nq ^ cfg_flag_inv});
    @(negedge clk);
    check_all(req);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check_all("R1");
    rst = 0;
    @(negedge clk);
    check_all("R1");

    // R2 / R3 / R4 encodings with no inversion, auto-ack on
    cfg_auto_ack = 1; cfg_dyn_ack = 1; cfg_flag_inv = 0;
    cyc("R3", 1, 1, 0, 0, 0, 0);
    cfg_dyn_ack = 0;
    cyc("R4", 1, 1, 0, 0, 0, 0);
    cfg_flag_inv = 1;
    cyc("R2", 1, 0, 0, 0, 0, 0);
    // R6 queue full: this load is dropped
    cfg_dyn_ack = 1;
    cyc("R6", 1, 1, 0, 0, 0, 0);
    // R5 config changes do not affect queued entries; drain in order
    cfg_flag_inv = 0; cfg_dyn_ack = 0;
    cyc("R5", 0, 0, 1, 0, 0, 0);
    cyc("R7", 0, 0, 1, 0, 0, 0);
    cyc("R5", 0, 0, 1, 0, 0, 0);
    cyc("R7", 0, 0, 0, 0, 0, 0);
    // R7 empty pop has no effect
    cyc("R7", 0, 0, 1, 0, 0, 0);
    // R8 / R10 receive decisions
    cyc("R8", 0, 0, 0, 1, 1, 0);
    cyc("R8", 0, 0, 0, 1, 1, 1);
    cyc("R10", 0, 0, 0, 1, 0, 0);
    cfg_flag_inv = 1;
    cyc("R8", 0, 0, 0, 1, 1, 1);
    // R9 auto-ack off
    cfg_auto_ack = 0;
    cyc("R9", 0, 0, 0, 1, 1, 1);
    cyc("R9", 1, 0, 0, 0, 0, 0);
    cyc("R9", 0, 0, 1, 0, 0, 0);
    cyc("R9", 0, 0, 0, 0, 0, 0);

    // constrained random phase
    for (int i = 0; i < 4000; i++) begin
      if (i % 40 == 0) begin
        cfg_auto_ack = ($urandom % 4) != 0;
        cfg_dyn_ack  = $urandom % 2;
        cfg_flag_inv = $urandom % 2;
      end
      cyc("R5", ($urandom % 3) == 0, $urandom % 2, ($urandom % 4) == 0,
          ($urandom % 3) == 0, ($urandom % 5) != 0, $urandom % 2);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule